// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Loopback and Receiver Wakeup

This block sends and receives asynchronous serial characters on a pair of line pins. Each character is framed as one low start bit, eight or nine data bits sent least significant bit first, and one high stop bit. Every bit lasts sixteen pulses of an external `baud_tick` strobe, so the baud-rate divider stays outside the block. Characters to be sent enter on a valid/ready stream. Received characters leave on a second valid/ready stream together with a framing-error flag.

Configuration arrives on plain level inputs, which must be held stable while a character is in flight. Loop mode cuts the receiver off from `rxd`. The receiver then reads one of two sources: the transmitter's own output inside the block, or the TX pad as sensed back through `txd_pad_in`. A one-cycle `rx_sleep` pulse puts the receiver to sleep. While asleep it keeps following character framing but delivers nothing. It wakes either after a full character time of idle line or on a character whose top data bit is 1, and that waking character is delivered.

Transmit stream rules: a character is taken on a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low for the whole frame. Receive stream rules: `rx_valid` holds `rx_data` and `rx_ferr` unchanged until a cycle with `rx_ready` high. A character that completes while the holding stage is full and not being drained is discarded.

Top module: `serlink_core`

## Requirements
- R1: After reset, `txd`=1, `tx_empty`=1, `tx_ready`=0 (all config inputs low), `rx_valid`=0 and `rx_awake`=1.
- R2: A sent frame is a 0 start bit, then the data bits least significant first (8 bits, or 9 when `cfg_nine`=1), then a 1 stop bit, each bit 16 baud ticks long. `txd` is 1 whenever no frame is in progress.
- R3: `tx_ready` equals `cfg_tx_en` while idle. After a transfer, `tx_ready` and `tx_empty` are 0 from the next cycle until the stop bit ends, and `txd` is 0 from the next cycle.
- R4: The receiver starts on a falling edge of its input and keeps the frame only if the input is still 0 at the 8th tick. It then samples each data bit and the stop bit 16 ticks apart. A low pulse shorter than 8 ticks yields no character. In 8-bit mode `rx_data[8]` is 0.
- R5: A stop bit sampled as 0 sets `rx_ferr`=1 alongside the character, which is still delivered. A good stop bit gives `rx_ferr`=0.
- R6: While `rx_valid`=1 and `rx_ready`=0, `rx_data` and `rx_ferr` stay unchanged. A character that completes in that state is discarded.
- R7: With `cfg_loop`=1 and `cfg_rsrc`=0, the receiver takes the transmitter's output and ignores `rxd`.
- R8: With `cfg_loop`=1 and `cfg_rsrc`=1, the receiver takes `txd_pad_in` and ignores `rxd`.
- R9: An `rx_sleep` pulse makes `rx_awake`=0 from the next cycle. While asleep, characters that do not wake the receiver do not raise `rx_valid`.
- R10: With `cfg_wake_mark`=0, a sleeping receiver wakes once its input has been 1 for 16×(data bits+2) consecutive ticks. The count starts at the last 0 or at sleep entry, whichever is later.
- R11: With `cfg_wake_mark`=1, a sleeping receiver wakes only on a character whose top data bit is 1 (bit 7, or bit 8 in 9-bit mode), and that character is delivered. Idle time and other characters leave it asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| cfg_tx_en | input | 1 | Transmitter enable |
| cfg_rx_en | input | 1 | Receiver enable |
| cfg_loop | input | 1 | Loop mode: receiver ignores `rxd` |
| cfg_rsrc | input | 1 | In loop mode: 0 internal transmitter output, 1 `txd_pad_in` |
| cfg_nine | input | 1 | 1 selects nine data bits, 0 eight |
| cfg_wake_mark | input | 1 | Wake source: 0 idle line, 1 top data bit set |
| rx_sleep | input | 1 | Pulse to put the receiver to sleep |
| tx_valid | input | 1 | Transmit character offered |
| tx_ready | output | 1 | Transmitter can take a character |
| tx_data | input | 9 | Character to send (bit 8 used in 9-bit mode) |
| rx_valid | output | 1 | Received character held |
| rx_ready | input | 1 | Consumer takes the held character |
| rx_data | output | 9 | Received character |
| rx_ferr | output | 1 | Held character had a 0 stop bit |
| txd | output | 1 | Serial transmit line |
| txd_pad_in | input | 1 | TX pad level sensed back for external loop |
| rxd | input | 1 | Serial receive line |
| tx_empty | output | 1 | No frame in progress |
| rx_awake | output | 1 | Receiver awake |

## Verification
A receiver state machine that picks the wrong sample point or bit count shows up at the ports within one frame, about 350 cycles here. The symptom is a shifted `rx_data` word or a wrong `rx_ferr`. A wake flag that is stuck or set too early shows within one idle character time, as a character appearing on `rx_valid` that should have been suppressed or one that never appears. A transmitter shift register or bit counter that is off by one corrupts `txd` at the centre of the affected bit, and the bench decodes `txd` bit by bit at those centres. Loop-source errors surface on the first looped character, because `rxd` is held low throughout those tests and any leak from it yields a garbage or framing-error character.

// File: rtl/serlink_pkg.sv
package serlink_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;

  typedef enum logic [1:0] {
    SRC_PIN,
    SRC_TX_INT,
    SRC_TX_PAD
  } line_src_t;
endpackage

// File: rtl/serlink_tx.sv
module serlink_tx #(
  parameter int OVS = 16,
  parameter int DW  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          nine,
  input  logic          valid,
  output logic          ready,
  input  logic [DW-1:0] data,
  output logic          txd,
  output logic          busy
);
  localparam int CW = $clog2(OVS);
  localparam int SW = DW + 1;
  localparam int BW = $clog2(SW + 1);

  logic [CW-1:0] tcnt;
  logic [SW-1:0] shreg;
  logic [BW-1:0] left;
  logic          txd_q, busy_q, accept;

  assign ready  = en & ~busy_q;
  assign accept = valid & ready;
  assign txd    = txd_q;
  assign busy   = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
      tcnt   <= '0;
      shreg  <= '1;
      left   <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      txd_q  <= 1'b0;
      tcnt   <= '0;
      shreg  <= nine ? {1'b1, data} : {2'b11, data[DW-2:0]};
      left   <= nine ? BW'(SW) : BW'(SW - 1);
    end else if (busy_q && tick) begin
      if (tcnt == CW'(OVS - 1)) begin
        tcnt <= '0;
        if (left == '0) begin
          busy_q <= 1'b0;
          txd_q  <= 1'b1;
        end else begin
          txd_q <= shreg[0];
          shreg <= {1'b1, shreg[SW-1:1]};
          left  <= left - 1'b1;
        end
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  a_r2_idle_line_high : assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> txd_q);
  a_r3_start_follows_accept : assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!txd_q && !ready));
endmodule

// File: rtl/serlink_rx.sv
module serlink_rx
  import serlink_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          nine,
  input  logic          din,
  output logic          done,
  output logic [DW-1:0] word,
  output logic          ferr
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DW);

  rx_state_t     state;
  logic          prev;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx, last;
  logic [DW-1:0] shreg;

  assign last = nine ? IW'(DW - 1) : IW'(DW - 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      prev  <= 1'b1;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
      done  <= 1'b0;
      word  <= '0;
      ferr  <= 1'b0;
    end else begin
      prev <= din;
      done <= 1'b0;
      if (!en) begin
        state <= RX_IDLE;
      end else begin
        unique case (state)
          RX_IDLE: if (prev && !din) begin
            state <= RX_START;
            cnt   <= '0;
          end
          RX_START: if (tick) begin
            if (cnt == CW'(OVS / 2 - 1)) begin
              cnt   <= '0;
              idx   <= '0;
              shreg <= '0;
              state <= din ? RX_IDLE : RX_DATA;
            end else cnt <= cnt + 1'b1;
          end
          RX_DATA: if (tick) begin
            if (cnt == CW'(OVS - 1)) begin
              cnt        <= '0;
              shreg[idx] <= din;
              if (idx == last) state <= RX_STOP;
              else idx <= idx + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          RX_STOP: if (tick) begin
            if (cnt == CW'(OVS - 1)) begin
              done  <= 1'b1;
              ferr  <= ~din;
              word  <= shreg;
              state <= RX_IDLE;
            end else cnt <= cnt + 1'b1;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  a_r4_done_after_stop : assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(state) == RX_STOP));
endmodule

// File: rtl/serlink_wake.sv
module serlink_wake #(
  parameter int OVS = 16,
  parameter int DW  = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  input  logic nine,
  input  logic mark,
  input  logic sleep_req,
  input  logic char_done,
  input  logic char_msb,
  output logic awake
);
  localparam int LMAX = OVS * (DW + 2);
  localparam int LW   = $clog2(LMAX + 1);

  logic [LW-1:0] icnt, lim;
  logic          idle_hit;

  assign lim      = nine ? LW'(LMAX) : LW'(OVS * (DW + 1));
  assign idle_hit = tick && din && (icnt == lim - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      awake <= 1'b1;
      icnt  <= '0;
    end else if (sleep_req) begin
      awake <= 1'b0;
      icnt  <= '0;
    end else begin
      if (!din) icnt <= '0;
      else if (tick && icnt < lim) icnt <= icnt + 1'b1;
      if (!awake && ((!mark && idle_hit) || (mark && char_done && char_msb)))
        awake <= 1'b1;
    end
  end

  a_r9_sleep_clears_awake : assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> !awake);
  a_r11_mark_mode_holds_sleep : assert property (@(posedge clk) disable iff (!rst_n)
    (!awake && mark && !char_done) |=> !awake);
  a_r10_idle_mode_needs_high_line : assert property (@(posedge clk) disable iff (!rst_n)
    (!awake && !mark && !din) |=> !awake);
endmodule

// File: rtl/serlink_core.sv
module serlink_core
  import serlink_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          cfg_tx_en,
  input  logic          cfg_rx_en,
  input  logic          cfg_loop,
  input  logic          cfg_rsrc,
  input  logic          cfg_nine,
  input  logic          cfg_wake_mark,
  input  logic          rx_sleep,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_ferr,
  output logic          txd,
  input  logic          txd_pad_in,
  input  logic          rxd,
  output logic          tx_empty,
  output logic          rx_awake
);
  line_src_t     src;
  logic          src_bit, sync1, sync2;
  logic          tx_busy, char_done, char_ferr, char_msb, deliver;
  logic [DW-1:0] char_word;

  serlink_tx #(.OVS(OVS), .DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(cfg_tx_en), .nine(cfg_nine),
    .valid(tx_valid), .ready(tx_ready), .data(tx_data), .txd(txd), .busy(tx_busy)
  );
  assign tx_empty = ~tx_busy;

  always_comb begin
    if (!cfg_loop) src = SRC_PIN;
    else if (cfg_rsrc) src = SRC_TX_PAD;
    else src = SRC_TX_INT;
    unique case (src)
      SRC_TX_INT: src_bit = txd;
      SRC_TX_PAD: src_bit = txd_pad_in;
      default:    src_bit = rxd;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= src_bit;
      sync2 <= sync1;
    end
  end

  serlink_rx #(.OVS(OVS), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(cfg_rx_en), .nine(cfg_nine),
    .din(sync2), .done(char_done), .word(char_word), .ferr(char_ferr)
  );

  assign char_msb = cfg_nine ? char_word[DW-1] : char_word[DW-2];

  serlink_wake #(.OVS(OVS), .DW(DW)) u_wake (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .din(sync2), .nine(cfg_nine),
    .mark(cfg_wake_mark), .sleep_req(rx_sleep), .char_done(char_done),
    .char_msb(char_msb), .awake(rx_awake)
  );

  assign deliver = char_done & (rx_awake | (cfg_wake_mark & char_msb));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_ferr  <= 1'b0;
    end else if (deliver && (!rx_valid || rx_ready)) begin
      rx_valid <= 1'b1;
      rx_data  <= char_word;
      rx_ferr  <= char_ferr;
    end else if (rx_valid && rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  a_r6_hold_under_backpressure : assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_ferr)));
  a_r9_no_delivery_while_asleep : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> rx_awake);
endmodule

// File: tb/tb_serlink_core.sv
`timescale 1ns / 1ps
module tb_serlink_core;
  localparam int BITCLK = 32;

  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
  logic cfg_tx_en = 0, cfg_rx_en = 0, cfg_loop = 0, cfg_rsrc = 0, cfg_nine = 0, cfg_wake_mark = 0;
  logic rx_sleep = 0, tx_valid = 0, rx_ready = 0, txd_pad_in = 1, rxd = 1;
  logic [8:0] tx_data = '0;
  logic tx_ready, rx_valid, rx_ferr, txd, tx_empty, rx_awake;
  logic [8:0] rx_data;
  int checks = 0, errors = 0;
  bit finished = 0;

  serlink_core dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cfg_tx_en(cfg_tx_en),
    .cfg_rx_en(cfg_rx_en), .cfg_loop(cfg_loop), .cfg_rsrc(cfg_rsrc), .cfg_nine(cfg_nine),
    .cfg_wake_mark(cfg_wake_mark), .rx_sleep(rx_sleep), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_ferr(rx_ferr), .txd(txd), .txd_pad_in(txd_pad_in), .rxd(rxd),
    .tx_empty(tx_empty), .rx_awake(rx_awake)
  );

  always #2.5 clk = ~clk;
  always @(negedge clk) if (rst_n) baud_tick = ~baud_tick;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic set_line(input bit on_pad, input bit v);
    if (on_pad) txd_pad_in = v; else rxd = v;
  endtask

  task automatic drive_frame(input logic [8:0] d, input bit nine, input bit stop_v, input bit on_pad);
    set_line(on_pad, 1'b0);
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      set_line(on_pad, d[i]);
      repeat (BITCLK) @(negedge clk);
    end
    set_line(on_pad, stop_v);
    repeat (BITCLK) @(negedge clk);
    set_line(on_pad, 1'b1);
  endtask

  task automatic idle_bits(input int n);
    repeat (n * BITCLK) @(negedge clk);
  endtask

  task automatic wait_rx(output bit got);
    got = 0;
    for (int i = 0; i < 30 * BITCLK; i++) begin
      if (rx_valid) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic pop;
    rx_ready = 1;
    @(negedge clk);
    rx_ready = 0;
  endtask

  task automatic push_tx(input logic [8:0] d);
    tx_data = d;
    tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic expect_rx(input logic [8:0] d, input bit fe, input string req);
    bit got;
    wait_rx(got);
    check(got, req, got, 1);
    check(rx_data == d, req, rx_data, d);
    check(rx_ferr == fe, req, rx_ferr, fe);
    pop();
  endtask

  task automatic t_reset;
    check(txd == 1, "R1 txd", txd, 1);
    check(tx_empty == 1, "R1 tx_empty", tx_empty, 1);
    check(tx_ready == 0, "R1 tx_ready", tx_ready, 0);
    check(rx_valid == 0, "R1 rx_valid", rx_valid, 0);
    check(rx_awake == 1, "R1 rx_awake", rx_awake, 1);
  endtask

  task automatic t_tx(input logic [8:0] d, input bit nine);
    logic [8:0] got = '0;
    cfg_nine = nine;
    cfg_tx_en = 1;
    @(negedge clk);
    check(tx_ready == 1, "R3 ready idle", tx_ready, 1);
    push_tx(d);
    check(tx_ready == 0 && tx_empty == 0, "R3 busy after accept", {tx_ready, tx_empty}, 0);
    check(txd == 0, "R3 start low", txd, 0);
    repeat (15) @(negedge clk);
    check(txd == 0, "R2 start bit", txd, 0);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      repeat (BITCLK) @(negedge clk);
      got[i] = txd;
    end
    repeat (BITCLK) @(negedge clk);
    check(txd == 1, "R2 stop bit", txd, 1);
    check(got == (nine ? d : {1'b0, d[7:0]}), "R2 data LSB first", got, d);
    repeat (BITCLK) @(negedge clk);
    check(tx_empty == 1 && txd == 1, "R2 idle high after frame", {tx_empty, txd}, 3);
    cfg_nine = 0;
  endtask

  task automatic t_rx(input logic [8:0] d, input bit nine, input bit stop_v, input string req);
    cfg_nine = nine;
    cfg_rx_en = 1;
    fork
      drive_frame(d, nine, stop_v, 0);
      expect_rx(nine ? d : {1'b0, d[7:0]}, !stop_v, req);
    join
    idle_bits(2);
    cfg_nine = 0;
  endtask

  task automatic t_glitch;
    bit got;
    rxd = 0;
    repeat (6) @(negedge clk);
    rxd = 1;
    idle_bits(14);
    check(rx_valid == 0, "R4 short low pulse ignored", rx_valid, 0);
    wait_rx(got);
  endtask

  task automatic t_backpressure;
    drive_frame(9'h03C, 0, 1, 0);
    idle_bits(1);
    check(rx_valid == 1 && rx_data == 9'h03C, "R6 first held", rx_data, 9'h03C);
    drive_frame(9'h0C3, 0, 1, 0);
    idle_bits(1);
    check(rx_valid == 1 && rx_data == 9'h03C, "R6 second dropped", rx_data, 9'h03C);
    pop();
    check(rx_valid == 0, "R6 drained", rx_valid, 0);
  endtask

  task automatic t_loop_int;
    cfg_loop = 1; cfg_rsrc = 0; rxd = 0;
    @(negedge clk);
    fork
      push_tx(9'h06E);
      expect_rx(9'h06E, 0, "R7 internal loop");
    join
    idle_bits(2);
  endtask

  task automatic t_loop_ext;
    cfg_rsrc = 1;
    @(negedge clk);
    fork
      drive_frame(9'h093, 0, 1, 1);
      expect_rx(9'h093, 0, "R8 pad loop");
    join
    idle_bits(2);
    rxd = 1;
    @(negedge clk);
    cfg_loop = 0; cfg_rsrc = 0;
    idle_bits(1);
  endtask

  task automatic t_sleep_idle;
    cfg_wake_mark = 0;
    rx_sleep = 1;
    @(negedge clk);
    rx_sleep = 0;
    check(rx_awake == 0, "R9 sleep entry", rx_awake, 0);
    drive_frame(9'h081, 0, 1, 0);
    @(negedge clk);
    check(rx_valid == 0, "R9 no data asleep", rx_valid, 0);
    check(rx_awake == 0, "R10 not yet idle", rx_awake, 0);
    idle_bits(10);
    check(rx_awake == 1, "R10 idle wake", rx_awake, 1);
    check(rx_valid == 0, "R9 suppressed char stays gone", rx_valid, 0);
    fork
      drive_frame(9'h022, 0, 1, 0);
      expect_rx(9'h022, 0, "R10 after wake");
    join
    idle_bits(2);
  endtask

  task automatic t_sleep_mark;
    cfg_wake_mark = 1;
    rx_sleep = 1;
    @(negedge clk);
    rx_sleep = 0;
    drive_frame(9'h005, 0, 1, 0);
    idle_bits(14);
    check(rx_valid == 0, "R11 low msb no data", rx_valid, 0);
    check(rx_awake == 0, "R11 idle no wake", rx_awake, 0);
    fork
      drive_frame(9'h085, 0, 1, 0);
      expect_rx(9'h085, 0, "R11 mark char delivered");
    join
    check(rx_awake == 1, "R11 awake", rx_awake, 1);
    idle_bits(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tx(9'h0A5, 0);
    t_tx(9'h1C3, 1);
    t_rx(9'h03C, 0, 1, "R4 8-bit rx");
    t_rx(9'h155, 1, 1, "R4 9-bit rx");
    t_rx(9'h05A, 0, 0, "R5 framing error");
    t_glitch();
    t_backpressure();
    t_loop_int();
    t_loop_ext();
    t_sleep_idle();
    t_sleep_mark();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule